// File: doc/BRIEF.md
# Interlaced Field Pair Frame Selector

This block sits next to a frame store that holds three progressive frames and decides which stored frame the read side fetches next. It watches a one-cycle frame-sync pulse from the reader. On each pulse it flips a field flag that marks whether the reader is producing the odd or the even field. It samples the writer's current frame index only when a field pair ends, which is the pulse that closes an even field. Both fields of a pair therefore always come from one stored frame.

At 12.5 stored frames per second and 50 output fields per second, each frame is normally fetched four times in the order odd, even, odd, even. When the writer has not moved on at a pair boundary, the same index is taken again and the frame repeats. A downstream line selector uses the field flag to keep or drop alternate lines. The reader latches the registered frame index at its own sync pulse. Because that index changes only on the clock edge that takes a sync pulse, it holds steady in every cycle between pulses.

Top module: `field_pair_ptr_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, field_o is 0 (odd field) and rd_idx_o is 0.
- R2: At each rising clock edge where fsync_i is 1, field_o inverts. field_o never changes at an edge where fsync_i is 0.
- R3: At an edge where fsync_i is 1 and field_o is 1 (even field, end of pair), rd_idx_o takes the value of wr_idx_i when wr_idx_i is a valid frame number (0, 1 or 2). The new value is visible from the next cycle, together with field_o = 0.
- R4: At an edge where fsync_i is 1 and field_o is 0 (odd field, middle of pair), rd_idx_o keeps its value whatever wr_idx_i holds.
- R5: At an edge where fsync_i is 0, rd_idx_o keeps its value whatever wr_idx_i does.
- R6: At a pair end, a wr_idx_i value of 3 or more (not a valid buffer) is ignored and rd_idx_o keeps its previous value.
- R7: When wr_idx_i at a pair end equals the current rd_idx_o, rd_idx_o stays the same. With a write index held steady over four sync pulses, the reader sees the same index for odd, even, odd and even fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | One-cycle frame-sync pulse from the read side |
| wr_idx_i | input | 2 | Frame index currently held by the write side |
| field_o | output | 1 | Field flag: 0 odd, 1 even |
| rd_idx_o | output | 2 | Frame index for the reader to fetch |

## Verification
The hardest case to reach is a write index that changes at the exact sync pulse closing an even field, or that is out of range there. A write index moving only in the middle of a pair never shows up at the output, so that case is also hard to see. The stimulus changes wr_idx_i in every cycle through all four codes and gives sync pulses irregular gaps, including back-to-back pulses. Every pulse phase therefore meets every index value, including code 3. A reference model in the bench predicts the flag and index after each edge. A reset applied in the middle of the run checks the return to the start state.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic {
    FIELD_ODD  = 1'b0,
    FIELD_EVEN = 1'b1
  } field_e;
endpackage

// File: rtl/fpc_field_tracker.sv
module fpc_field_tracker
  import fpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  output logic field_o,
  output logic pair_end_o
);
  field_e field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      field_q <= FIELD_ODD;
    else if (fsync_i) field_q <= (field_q == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
  end

  assign field_o    = field_q;
  // sync closing an even field ends the pair
  assign pair_end_o = fsync_i && (field_q == FIELD_EVEN);

  p_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (field_o != $past(field_o)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> $stable(field_o));
endmodule

// File: rtl/fpc_idx_latch.sv
module fpc_idx_latch #(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic [IDX_W-1:0] rd_idx_o
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_BUF - 1);

  logic [IDX_W-1:0] idx_q;
  logic             idx_ok;

  assign idx_ok = (wr_idx_i <= MAX_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (load_i && idx_ok)  idx_q <= wr_idx_i;
  end

  assign rd_idx_o = idx_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rd_idx_o));
  p_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (wr_idx_i > MAX_IDX)) |=> $stable(rd_idx_o));
  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_o <= MAX_IDX);
endmodule

// File: rtl/field_pair_ptr_ctrl.sv
module field_pair_ptr_ctrl #(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             field_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  logic pair_end;

  fpc_field_tracker u_field (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .field_o    (field_o),
    .pair_end_o (pair_end)
  );

  fpc_idx_latch #(
    .NUM_BUF (NUM_BUF),
    .IDX_W   (IDX_W)
  ) u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pair_end),
    .wr_idx_i (wr_idx_i),
    .rd_idx_o (rd_idx_o)
  );

  p_mid_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_i && !field_o) |=> $stable(rd_idx_o));
  p_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_i && field_o && (32'(wr_idx_i) < NUM_BUF)) |=> (rd_idx_o == $past(wr_idx_i)) && !field_o);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!field_o && rd_idx_o == '0));
endmodule

// File: tb/sim_field_pair_ptr_ctrl.sv
module sim_field_pair_ptr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic [1:0] wr_idx = 2'd0;
  logic       field;
  logic [1:0] rd_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic       m_field;
  logic [1:0] m_idx;

  always #5 clk = ~clk;

  field_pair_ptr_ctrl u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .fsync_i  (fsync),
    .wr_idx_i (wr_idx),
    .field_o  (field),
    .rd_idx_o (rd_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, model the edge, sample 1ns after it
  task automatic step(input logic fs, input logic [1:0] wi);
    string ireq;
    @(negedge clk);
    fsync  = fs;
    wr_idx = wi;
    @(posedge clk);
    #1;
    if (!fs)                    ireq = "R5";
    else if (!m_field)          ireq = "R4";
    else if (wi == 2'd3)        ireq = "R6";
    else if (wi == m_idx)       ireq = "R7";
    else                        ireq = "R3";
    if (fs) begin
      if (m_field && wi <= 2'd2) m_idx = wi;
      m_field = ~m_field;
    end
    chk("R2", int'(field), int'(m_field));
    chk(ireq, int'(rd_idx), int'(m_idx));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fsync = 1'b0;
    #1;
    chk("R1", int'(field), 0);
    chk("R1", int'(rd_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_field = 1'b0;
    m_idx   = 2'd0;
    @(posedge clk);
    #1;
    chk("R1", int'(field), 0);
    chk("R1", int'(rd_idx), 0);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: steady frame read as odd, even, odd, even
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 4; k++) begin
        step(1'b1, 2'(f));
        step(1'b0, 2'(f));
        chk("R7", int'(field), (k + 1) % 2);
      end
    end
    // sweep: gaps 0..3 between pulses, write index churns each cycle
    for (int gap = 0; gap < 4; gap++) begin
      for (int n = 0; n < 64; n++) begin
        step(1'b1, 2'((n * 3 + gap) % 4));
        for (int g = 0; g < gap; g++) step(1'b0, 2'((n + g + 1) % 4));
      end
    end
    // R6: every pulse offers invalid index 3
    for (int n = 0; n < 8; n++) step(1'b1, 2'd3);
    // mid-run reset
    step(1'b1, 2'd2);
    step(1'b1, 2'd2);
    do_reset();
    for (int n = 0; n < 40; n++) step(1'((n % 3) != 0), 2'(n % 4));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule